// File: doc/BRIEF.md
# DRAM Read/Write Bus Turnaround Controller

This block decides, cycle by cycle, whether the DRAM data bus is serving reads or writes. It keeps burst-granular occupancy counts for a read queue and a write queue. It accepts or refuses enqueue requests, and a request that spans several bursts is taken whole or not at all. It grants the command scheduler permission to issue one command type at a time. When the bus changes direction, it holds both grants low for a fixed turnaround time.

Writes are collected until the write queue passes a high watermark, or until there are no reads left to serve. The block then drains writes. It returns to reads only after a minimum number of writes has been issued in the current write period and the write queue has fallen to a low watermark. A read whose whole address range is still held by a pending write is answered from the write queue. Such a read never enters the read queue. A refused enqueue is remembered, and a one-cycle retry pulse is given once space is released. Addresses and lengths are in burst units.

Top module: `rw_turnaround_ctrl`

## Requirements
- R1: After reset, bus_mode is 0, both grants are low, both levels are 0 and no accept, hit or retry pulse is present.
- R2: bus_mode encodes 0 = read, 1 = read-to-write turnaround, 2 = write, 3 = write-to-read turnaround. grant_rd is high only in mode 0 with reads waiting. grant_wr is high only in mode 2 with writes pending. An rd_issue or wr_issue strobe given while its grant is low changes nothing.
- R3: A read request of N bursts (N at least 1) that is not a write-queue hit is accepted only if the waiting reads, plus the reads in the response stage, plus N, fit in RQ_DEPTH. Reads that have been issued but not yet answered by resp_done still count in rd_level.
- R4: A write request of N bursts is accepted only if wr_level plus N fits in WQ_DEPTH. Otherwise nothing of it is taken.
- R5: A read whose range [addr, addr+N) lies inside the not-yet-issued part of one pending write gives wq_hit and rd_accept in the following cycle, and rd_level does not change. Write bursts leave a write entry from its lowest address upward.
- R6: In mode 0, a write level above HI_MARK moves the bus to mode 1 on the next cycle, even with reads waiting.
- R7: In mode 0, with no reads waiting and at least one write pending, the bus moves to mode 1.
- R8: Mode 1 lasts exactly T_RTW cycles and always leads to mode 2. Mode 2 is entered only from mode 1.
- R9: Mode 3 lasts exactly T_WTR cycles and then leads to mode 0.
- R10: Mode 2 is left when the write queue is empty, or when all of the following hold: at least MIN_WR writes have been issued since this write period began, wr_level is at most LO_MARK, and reads are waiting. The count of writes issued starts again from zero in each write period.
- R11: A refused read (or write) request sets a pending flag. The next cycle in which a read response (or a write burst) frees space gives a one-cycle rd_retry (or wr_retry) pulse.
- R12: A request with a burst count of zero is ignored: no accept, no hit, no level change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | input | 1 | Read enqueue request |
| rd_req_addr | input | AW | Read start address, in bursts |
| rd_req_bursts | input | BW | Read length, in bursts |
| wr_req_valid | input | 1 | Write enqueue request |
| wr_req_addr | input | AW | Write start address, in bursts |
| wr_req_bursts | input | BW | Write length, in bursts |
| rd_issue | input | 1 | Scheduler issued one read burst |
| wr_issue | input | 1 | Scheduler issued one write burst |
| resp_done | input | 1 | One read response left the response stage |
| bus_mode | output | 2 | Current bus direction state |
| grant_rd | output | 1 | A read burst may issue |
| grant_wr | output | 1 | A write burst may issue |
| rd_accept | output | 1 | Previous read request taken |
| wr_accept | output | 1 | Previous write request taken |
| wq_hit | output | 1 | Previous read served from the write queue |
| rd_retry | output | 1 | Read space freed after a refusal |
| wr_retry | output | 1 | Write space freed after a refusal |
| rd_level | output | RCW | Read bursts waiting plus in response stage |
| wr_level | output | WCW | Write bursts pending |

## Verification
A wrong occupancy count appears one cycle after the enqueue, on rd_level or wr_level and on the accept pulse. It also moves the mode decisions, so a miscounted write level shifts the watermark switch by a visible cycle. A stale turnaround timer or write-period counter shows as bus_mode staying in or leaving a state one or more cycles off from the expected count. An error in the write-entry book shows as a wrong wq_hit on the very next read, including after a partly issued write.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  typedef enum logic [1:0] {
    BUS_RD    = 2'd0,
    BUS_RD2WR = 2'd1,
    BUS_WR    = 2'd2,
    BUS_WR2RD = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/rwt_occupancy.sv
module rwt_occupancy #(
  parameter int RQ_DEPTH = 8,
  parameter int WQ_DEPTH = 8,
  parameter int MAX_BURSTS = 4,
  localparam int BW = $clog2(MAX_BURSTS + 1),
  localparam int RCW = $clog2(RQ_DEPTH + 1),
  localparam int WCW = $clog2(WQ_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_req_valid,
  input  logic [BW-1:0]  rd_req_bursts,
  input  logic           rd_hit,
  input  logic           wr_req_valid,
  input  logic [BW-1:0]  wr_req_bursts,
  input  logic           rd_fire,
  input  logic           wr_fire,
  input  logic           resp_done,
  output logic [RCW-1:0] rd_wait,
  output logic [RCW-1:0] rd_level,
  output logic [WCW-1:0] wr_cnt,
  output logic           wr_take,
  output logic           rd_accept_o,
  output logic           wq_hit_o,
  output logic           wr_accept_o,
  output logic           rd_retry_o,
  output logic           wr_retry_o
);
  logic [RCW-1:0] rd_wait_q, rd_resp_q;
  logic [WCW-1:0] wr_cnt_q;
  logic rd_pend_q, wr_pend_q;
  logic rd_live, rd_room, rd_take, rd_rej;
  logic wr_live, wr_room, wr_rej, resp_ok;

  always_comb begin
    rd_live = rd_req_valid && (rd_req_bursts != '0);
    rd_room = (32'(rd_wait_q) + 32'(rd_resp_q) + 32'(rd_req_bursts)) <= 32'(RQ_DEPTH);
    rd_take = rd_live && !rd_hit && rd_room;
    rd_rej  = rd_live && !rd_hit && !rd_room;
    wr_live = wr_req_valid && (wr_req_bursts != '0);
    wr_room = (32'(wr_cnt_q) + 32'(wr_req_bursts)) <= 32'(WQ_DEPTH);
    wr_take = wr_live && wr_room;
    wr_rej  = wr_live && !wr_room;
    resp_ok = resp_done && (rd_resp_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wait_q   <= '0;
      rd_resp_q   <= '0;
      wr_cnt_q    <= '0;
      rd_pend_q   <= 1'b0;
      wr_pend_q   <= 1'b0;
      rd_accept_o <= 1'b0;
      wq_hit_o    <= 1'b0;
      wr_accept_o <= 1'b0;
      rd_retry_o  <= 1'b0;
      wr_retry_o  <= 1'b0;
    end else begin
      rd_wait_q <= RCW'(32'(rd_wait_q) + (rd_take ? 32'(rd_req_bursts) : 32'd0) - 32'(rd_fire));
      rd_resp_q <= RCW'(32'(rd_resp_q) + 32'(rd_fire) - 32'(resp_ok));
      wr_cnt_q  <= WCW'(32'(wr_cnt_q) + (wr_take ? 32'(wr_req_bursts) : 32'd0) - 32'(wr_fire));
      rd_accept_o <= rd_live && (rd_hit || rd_room);
      wq_hit_o    <= rd_live && rd_hit;
      wr_accept_o <= wr_take;
      rd_retry_o  <= rd_pend_q && resp_ok;
      wr_retry_o  <= wr_pend_q && wr_fire;
      if (rd_rej) rd_pend_q <= 1'b1;
      else if (resp_ok) rd_pend_q <= 1'b0;
      if (wr_rej) wr_pend_q <= 1'b1;
      else if (wr_fire) wr_pend_q <= 1'b0;
    end
  end

  assign rd_wait  = rd_wait_q;
  assign rd_level = RCW'(32'(rd_wait_q) + 32'(rd_resp_q));
  assign wr_cnt   = wr_cnt_q;

  // R3
  rd_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_wait_q) + 32'(rd_resp_q)) <= 32'(RQ_DEPTH));
  // R4
  wr_cap_chk: assert property (@(posedge clk) disable iff (rst)
    32'(wr_cnt_q) <= 32'(WQ_DEPTH));
  // R11
  rd_retry_chk: assert property (@(posedge clk) disable iff (rst)
    rd_retry_o |-> $past(resp_done));
  // R12
  zero_req_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && rd_req_bursts == '0) |=> !rd_accept_o);
endmodule

// File: rtl/rwt_wr_book.sv
module rwt_wr_book #(
  parameter int AW = 16,
  parameter int WQ_DEPTH = 8,
  parameter int MAX_BURSTS = 4,
  localparam int BW = $clog2(MAX_BURSTS + 1),
  localparam int PW = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_take,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_bursts,
  input  logic          wr_fire,
  input  logic [AW-1:0] rd_addr,
  input  logic [BW-1:0] rd_bursts,
  output logic          rd_hit
);
  logic [AW-1:0] base_mem [WQ_DEPTH];
  logic [BW-1:0] len_mem [WQ_DEPTH];
  logic [WQ_DEPTH-1:0] valid_q;
  logic [WQ_DEPTH-1:0] hit_vec;
  logic [PW-1:0] head_q, tail_q;
  logic [BW-1:0] used_q;
  logic [AW:0] rd_lo, rd_hi;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (32'(p) == WQ_DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign rd_lo = {1'b0, rd_addr};
  assign rd_hi = rd_lo + (AW+1)'(rd_bursts);

  // Each slot compares the read range against its unissued part.
  generate
    for (genvar g = 0; g < WQ_DEPTH; g++) begin : g_slot
      logic [AW:0] lo, hi;
      assign lo = {1'b0, base_mem[g]} + ((32'(head_q) == g) ? (AW+1)'(used_q) : '0);
      assign hi = {1'b0, base_mem[g]} + (AW+1)'(len_mem[g]);
      assign hit_vec[g] = valid_q[g] && (rd_bursts != '0) && (rd_lo >= lo) && (rd_hi <= hi);
    end
  endgenerate

  assign rd_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (wr_take) begin
      base_mem[tail_q] <= wr_addr;
      len_mem[tail_q]  <= wr_bursts;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      used_q  <= '0;
    end else begin
      if (wr_take) begin
        valid_q[tail_q] <= 1'b1;
        tail_q <= bump(tail_q);
      end
      if (wr_fire) begin
        if ((used_q + BW'(1)) == len_mem[head_q]) begin
          valid_q[head_q] <= 1'b0;
          head_q <= bump(head_q);
          used_q <= '0;
        end else begin
          used_q <= used_q + BW'(1);
        end
      end
    end
  end

  // R5
  retire_live_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> valid_q[head_q]);
endmodule

// File: rtl/rwt_mode_fsm.sv
module rwt_mode_fsm
  import rwt_pkg::*;
#(
  parameter int RQ_DEPTH = 8,
  parameter int WQ_DEPTH = 8,
  parameter int HI_MARK = 6,
  parameter int LO_MARK = 2,
  parameter int MIN_WR = 3,
  parameter int T_RTW = 2,
  parameter int T_WTR = 3,
  localparam int RCW = $clog2(RQ_DEPTH + 1),
  localparam int WCW = $clog2(WQ_DEPTH + 1),
  localparam int TMAX = (T_RTW > T_WTR) ? T_RTW : T_WTR,
  localparam int TW = $clog2(TMAX + 1),
  localparam int DW = $clog2(MIN_WR + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RCW-1:0] rd_wait,
  input  logic [WCW-1:0] wr_cnt,
  input  logic           rd_issue,
  input  logic           wr_issue,
  output logic [1:0]     mode,
  output logic           grant_rd,
  output logic           grant_wr,
  output logic           rd_fire,
  output logic           wr_fire
);
  bus_mode_e mode_q;
  logic [TW-1:0] tmr_q;
  logic [DW-1:0] wr_done_q;
  logic go_write, go_read;

  assign grant_rd = (mode_q == BUS_RD) && (rd_wait != '0);
  assign grant_wr = (mode_q == BUS_WR) && (wr_cnt != '0);
  assign rd_fire  = rd_issue && grant_rd;
  assign wr_fire  = wr_issue && grant_wr;
  assign mode     = mode_q;

  always_comb begin
    go_write = (32'(wr_cnt) > 32'(HI_MARK)) || ((rd_wait == '0) && (wr_cnt != '0));
    go_read  = (wr_cnt == '0) ||
               ((32'(wr_done_q) >= 32'(MIN_WR)) && (32'(wr_cnt) <= 32'(LO_MARK)) && (rd_wait != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= BUS_RD;
      tmr_q     <= '0;
      wr_done_q <= '0;
    end else begin
      case (mode_q)
        BUS_RD: if (go_write) begin
          mode_q <= BUS_RD2WR;
          tmr_q  <= TW'(T_RTW - 1);
        end
        BUS_RD2WR: if (tmr_q == '0) begin
          mode_q    <= BUS_WR;
          wr_done_q <= '0;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        BUS_WR: begin
          if (wr_fire && (32'(wr_done_q) < 32'(MIN_WR))) wr_done_q <= wr_done_q + 1'b1;
          if (go_read) begin
            mode_q <= BUS_WR2RD;
            tmr_q  <= TW'(T_WTR - 1);
          end
        end
        default: if (tmr_q == '0) begin
          mode_q <= BUS_RD;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
      endcase
    end
  end

  // R8
  rtw_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == BUS_WR) |-> ($past(mode_q) == BUS_WR || $past(mode_q) == BUS_RD2WR));
  // R10
  wr_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == BUS_WR2RD && $past(mode_q) == BUS_WR) |->
      ($past(wr_cnt) == '0 || 32'($past(wr_done_q)) >= 32'(MIN_WR)));
  // R6
  hi_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == BUS_RD && 32'(wr_cnt) > 32'(HI_MARK)) |=> (mode_q == BUS_RD2WR));
  // R2
  no_dual_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_fire && wr_fire));
endmodule

// File: rtl/rw_turnaround_ctrl.sv
module rw_turnaround_ctrl #(
  parameter int AW = 16,
  parameter int RQ_DEPTH = 8,
  parameter int WQ_DEPTH = 8,
  parameter int MAX_BURSTS = 4,
  parameter int HI_MARK = 6,
  parameter int LO_MARK = 2,
  parameter int MIN_WR = 3,
  parameter int T_RTW = 2,
  parameter int T_WTR = 3,
  localparam int BW = $clog2(MAX_BURSTS + 1),
  localparam int RCW = $clog2(RQ_DEPTH + 1),
  localparam int WCW = $clog2(WQ_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_req_valid,
  input  logic [AW-1:0]  rd_req_addr,
  input  logic [BW-1:0]  rd_req_bursts,
  input  logic           wr_req_valid,
  input  logic [AW-1:0]  wr_req_addr,
  input  logic [BW-1:0]  wr_req_bursts,
  input  logic           rd_issue,
  input  logic           wr_issue,
  input  logic           resp_done,
  output logic [1:0]     bus_mode,
  output logic           grant_rd,
  output logic           grant_wr,
  output logic           rd_accept,
  output logic           wr_accept,
  output logic           wq_hit,
  output logic           rd_retry,
  output logic           wr_retry,
  output logic [RCW-1:0] rd_level,
  output logic [WCW-1:0] wr_level
);
  logic [RCW-1:0] rd_wait;
  logic [WCW-1:0] wr_cnt;
  logic rd_hit, wr_take, rd_fire, wr_fire;

  rwt_wr_book #(.AW(AW), .WQ_DEPTH(WQ_DEPTH), .MAX_BURSTS(MAX_BURSTS)) u_book (
    .clk(clk), .rst(rst), .wr_take(wr_take), .wr_addr(wr_req_addr),
    .wr_bursts(wr_req_bursts), .wr_fire(wr_fire), .rd_addr(rd_req_addr),
    .rd_bursts(rd_req_bursts), .rd_hit(rd_hit)
  );

  rwt_occupancy #(.RQ_DEPTH(RQ_DEPTH), .WQ_DEPTH(WQ_DEPTH), .MAX_BURSTS(MAX_BURSTS)) u_occ (
    .clk(clk), .rst(rst), .rd_req_valid(rd_req_valid), .rd_req_bursts(rd_req_bursts),
    .rd_hit(rd_hit), .wr_req_valid(wr_req_valid), .wr_req_bursts(wr_req_bursts),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .resp_done(resp_done), .rd_wait(rd_wait),
    .rd_level(rd_level), .wr_cnt(wr_cnt), .wr_take(wr_take), .rd_accept_o(rd_accept),
    .wq_hit_o(wq_hit), .wr_accept_o(wr_accept), .rd_retry_o(rd_retry), .wr_retry_o(wr_retry)
  );

  rwt_mode_fsm #(.RQ_DEPTH(RQ_DEPTH), .WQ_DEPTH(WQ_DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK),
                 .MIN_WR(MIN_WR), .T_RTW(T_RTW), .T_WTR(T_WTR)) u_fsm (
    .clk(clk), .rst(rst), .rd_wait(rd_wait), .wr_cnt(wr_cnt), .rd_issue(rd_issue),
    .wr_issue(wr_issue), .mode(bus_mode), .grant_rd(grant_rd), .grant_wr(grant_wr),
    .rd_fire(rd_fire), .wr_fire(wr_fire)
  );

  assign wr_level = wr_cnt;
endmodule

// File: tb/test_rw_turnaround_ctrl.sv
module test_rw_turnaround_ctrl;
  localparam int AW = 16;
  localparam int BW = 3;
  localparam int RCW = 4;
  localparam int WCW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req_valid = 0, wr_req_valid = 0, rd_issue = 0, wr_issue = 0, resp_done = 0;
  logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
  logic [BW-1:0] rd_req_bursts = '0, wr_req_bursts = '0;
  logic [1:0] bus_mode;
  logic grant_rd, grant_wr, rd_accept, wr_accept, wq_hit, rd_retry, wr_retry;
  logic [RCW-1:0] rd_level;
  logic [WCW-1:0] wr_level;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rw_turnaround_ctrl i_rw_turnaround_ctrl (
    .clk(clk), .rst(rst), .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
    .rd_req_bursts(rd_req_bursts), .wr_req_valid(wr_req_valid), .wr_req_addr(wr_req_addr),
    .wr_req_bursts(wr_req_bursts), .rd_issue(rd_issue), .wr_issue(wr_issue),
    .resp_done(resp_done), .bus_mode(bus_mode), .grant_rd(grant_rd), .grant_wr(grant_wr),
    .rd_accept(rd_accept), .wr_accept(wr_accept), .wq_hit(wq_hit), .rd_retry(rd_retry),
    .wr_retry(wr_retry), .rd_level(rd_level), .wr_level(wr_level)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rd_req_valid = 0; wr_req_valid = 0; rd_issue = 0; wr_issue = 0; resp_done = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic rd_enq(input int addr, input int n);
    rd_req_valid = 1; rd_req_addr = AW'(addr); rd_req_bursts = BW'(n);
    step();
    rd_req_valid = 0;
  endtask

  task automatic wr_enq(input int addr, input int n);
    wr_req_valid = 1; wr_req_addr = AW'(addr); wr_req_bursts = BW'(n);
    step();
    wr_req_valid = 0;
  endtask

  task automatic pulse_rd();
    rd_issue = 1; step(); rd_issue = 0;
  endtask

  task automatic pulse_wr();
    wr_issue = 1; step(); wr_issue = 0;
  endtask

  task automatic pulse_resp();
    resp_done = 1; step(); resp_done = 0;
  endtask

  task automatic wait_mode(input string tag, input int m);
    for (int i = 0; i < 40 && int'(bus_mode) != m; i++) step();
    chk(tag, int'(bus_mode), m);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mode", bus_mode, 0);
    chk("R1 grant_rd", grant_rd, 0);
    chk("R1 grant_wr", grant_wr, 0);
    chk("R1 rd_level", rd_level, 0);
    chk("R1 wr_level", wr_level, 0);
    chk("R1 pulses", {rd_accept, wr_accept, wq_hit, rd_retry, wr_retry}, 0);
  endtask

  task automatic t_hit();
    do_reset();
    rd_enq(50, 1);
    chk("R2 grant_rd with read", grant_rd, 1);
    chk("R2 grant_wr in read mode", grant_wr, 0);
    wr_enq(300, 2);
    chk("R4 wr accept", wr_accept, 1);
    chk("R4 wr_level", wr_level, 2);
    rd_enq(301, 1);
    chk("R5 hit inside", wq_hit, 1);
    chk("R5 hit accept", rd_accept, 1);
    chk("R5 rd_level unchanged", rd_level, 1);
    rd_enq(301, 2);
    chk("R5 range past end", wq_hit, 0);
    chk("R3 rd_level after miss", rd_level, 3);
    rd_enq(299, 1);
    chk("R5 below start", wq_hit, 0);
    for (int i = 0; i < 4; i++) pulse_rd();
    wait_mode("R7 write after reads drain", 2);
    pulse_wr();
    chk("R5 one burst retired", wr_level, 1);
    rd_enq(300, 1);
    chk("R5 issued burst no hit", wq_hit, 0);
    rd_enq(301, 1);
    chk("R5 remaining burst hit", wq_hit, 1);
  endtask

  task automatic t_hi_water();
    do_reset();
    rd_enq(10, 1);
    wr_enq(100, 4);
    wr_enq(104, 2);
    step(); step();
    chk("R6 at mark stays read", bus_mode, 0);
    wr_enq(106, 1);
    chk("R6 wr_level 7", wr_level, 7);
    chk("R6 decision pending", bus_mode, 0);
    step();
    chk("R6 switch to rd2wr", bus_mode, 1);
    chk("R8 no grant_rd in turnaround", grant_rd, 0);
    chk("R8 no grant_wr in turnaround", grant_wr, 0);
    pulse_wr();
    chk("R2 write ignored in turnaround", wr_level, 7);
    chk("R8 second turnaround cycle", bus_mode, 1);
    step();
    chk("R8 write after T_RTW", bus_mode, 2);
    chk("R2 grant_wr in write", grant_wr, 1);
    for (int i = 0; i < 3; i++) pulse_wr();
    step();
    chk("R10 above low mark stays", bus_mode, 2);
    chk("R10 wr_level 4", wr_level, 4);
    pulse_wr(); pulse_wr();
    chk("R10 level at low mark", wr_level, 2);
    chk("R10 decision pending", bus_mode, 2);
    step();
    chk("R10 leave write", bus_mode, 3);
    pulse_rd();
    chk("R9 turnaround cycle 2", bus_mode, 3);
    step();
    chk("R9 turnaround cycle 3", bus_mode, 3);
    step();
    chk("R9 read after T_WTR", bus_mode, 0);
    chk("R2 read ignored in turnaround", grant_rd, 1);
  endtask

  task automatic t_min_wr();
    do_reset();
    wr_enq(200, 4);
    chk("R7 decision pending", bus_mode, 0);
    step();
    chk("R7 empty reads switch", bus_mode, 1);
    rd_enq(20, 1);
    wait_mode("R8 enter write", 2);
    pulse_wr(); pulse_wr();
    step(); step();
    chk("R10 below MIN_WR stays", bus_mode, 2);
    pulse_wr();
    chk("R10 third write", wr_level, 1);
    step();
    chk("R10 leave after MIN_WR", bus_mode, 3);
    wait_mode("R9 back to read", 0);
    pulse_rd();
    wait_mode("R7 second write period", 2);
    rd_enq(21, 1);
    step(); step(); step();
    chk("R10 count restarts", bus_mode, 2);
  endtask

  task automatic t_full_retry();
    do_reset();
    rd_enq(0, 4);
    chk("R3 accept 4", rd_accept, 1);
    rd_enq(4, 2);
    chk("R3 level 6", rd_level, 6);
    rd_enq(6, 4);
    chk("R3 no partial accept", rd_accept, 0);
    chk("R3 level held", rd_level, 6);
    rd_enq(6, 2);
    chk("R3 exact fit", rd_accept, 1);
    rd_enq(8, 1);
    chk("R3 full reject", rd_accept, 0);
    chk("R11 no retry yet", rd_retry, 0);
    pulse_rd();
    chk("R3 response stage counted", rd_level, 8);
    rd_enq(8, 1);
    chk("R3 still full", rd_accept, 0);
    pulse_resp();
    chk("R11 rd retry pulse", rd_retry, 1);
    chk("R3 level after response", rd_level, 7);
    step();
    chk("R11 rd retry one cycle", rd_retry, 0);
    do_reset();
    rd_enq(0, 1);
    wr_enq(100, 4);
    wr_enq(104, 4);
    chk("R4 fill to depth", wr_level, 8);
    wr_enq(108, 1);
    chk("R4 full reject", wr_accept, 0);
    wait_mode("R6 full switch", 2);
    chk("R11 no wr retry yet", wr_retry, 0);
    pulse_wr();
    chk("R11 wr retry pulse", wr_retry, 1);
    chk("R4 level after issue", wr_level, 7);
  endtask

  task automatic t_zero();
    do_reset();
    rd_enq(5, 0);
    chk("R12 zero read no accept", rd_accept, 0);
    chk("R12 zero read level", rd_level, 0);
    wr_enq(5, 0);
    chk("R12 zero write no accept", wr_accept, 0);
    chk("R12 zero write level", wr_level, 0);
    chk("R12 mode unchanged", bus_mode, 0);
  endtask

  initial begin
    t_reset();
    t_hit();
    t_hi_water();
    t_min_wr();
    t_full_retry();
    t_zero();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule